// File: doc/BRIEF.md
# 32-Pin GPIO Bank with Dual Interrupt Targets

This block is a memory-mapped bank of 32 general-purpose pins. Each pin can be driven from a data-out register or left as an input. Whether a pin is driven is set per pin by a direction register, in which a 1 means the pin is an input. Input pins go through a two-flop synchronizer. After that, each input pin can raise an event on a rising edge, a falling edge, a high level or a low level.

Every event sets the pin's bit in two separate status registers. Each status register has its own enable register and drives its own interrupt line, so two processors can each own one target. A third output, a wakeup request, fires on events at pins marked for wakeup, but only while the configuration register allows it.

Software reaches the block through a simple synchronous register port that accepts byte, halfword and word accesses. The data-out, interrupt-enable and wakeup-enable registers also have set and clear aliases. These let software change single bits without a read-modify-write. A soft reset can be requested through the configuration register.

Top module: `gpio_bank32`

## Requirements
- R1: After reset, direction reads 0xFFFFFFFF (all inputs) and pin_drive_en is 0. Status, enables, wakeup enable, detect selects, debounce fields, configuration and data out are 0. Control reads 2, the status register at 0x14 reads 1, revision at 0x00 reads the REVISION parameter, and irq1, irq2 and wake are low.
- R2: Direction lives at 0x34. A 1 bit makes the pin an input. pin_drive_en is the bitwise inverse of direction, and pin_out always shows data out (0x3C).
- R3: Each alias changes only the bits written as 1. 0x90/0x94 clear/set data out. 0x60/0x64 clear/set target-1 enable (0x1C). 0x70/0x74 clear/set target-2 enable (0x2C). 0x80/0x84 clear/set wakeup enable (0x20). A read of an alias returns the register behind it.
- R4: Rising (0x48) and falling (0x4C) selects detect edges against the previous synchronised sample. An event sets the pin's bit in both status registers, 0x18 (target 1) and 0x28 (target 2). A pin change is visible in status three clock edges later.
- R5: Level-low (0x40) and level-high (0x44) selects set status on every cycle that the selected level is present. A clear therefore does not remove the bit while the level lasts.
- R6: Pins with direction bit 0 (driven) never set status.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. The two status registers are cleared independently.
- R8: irq1 is the OR of status 0x18 ANDed with enable 0x1C. irq2 is the same for 0x28 and 0x2C.
- R9: wake goes high one cycle after an event on a pin whose wakeup-enable bit is set, but only when configuration bit 2 is 1 and configuration bits 4:3 are nonzero.
- R10: A write to configuration (0x10) whose bit 1 is 1 returns every register to its reset value except data out. The register then keeps the written value ANDed with 0x1D. Control (0x30) keeps 3 bits.
- R11: bus_size is 0 for a byte, 1 for a halfword and 2 or 3 for a word. The value sits in the low bits of bus_wdata and goes to lane bus_addr[1:0]. Byte and halfword writes to plain registers keep the other lanes. Writes to status and alias registers use the shifted value alone, so zeros in other lanes change nothing.
- R12: Reads return the addressed lane shifted down to bit 0, masked to the access size. Unmapped offsets read 0. Writes to revision, 0x14 and data in (0x38) have no effect.
- R13: Debounce enable (0x50, 32 bits) and debounce time (0x54, 8 bits) read back what was written and do not change detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write value, right-aligned |
| bus_rdata | output | 32 | Read value for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data for the pins |
| pin_drive_en | output | 32 | 1 where the pin is driven |
| irq1 | output | 1 | Interrupt to target 1 |
| irq2 | output | 1 | Interrupt to target 2 |
| wake | output | 1 | Wakeup request |

## Verification
The bench targets the lanes hidden by a partial write. A byte clear to an alias or status register is used to catch a design that merges there, because such a design would wipe bits in the other lanes. A byte write to data out is used to catch a design that does not merge, because the upper bytes would be lost.

It clears a level-detected status bit while the level is still present, to catch a design that treats levels like edges and lets the bit drop. It drives a level on an output pin, which must stay silent. It clears one target's status and checks that the other target's copy stays set.

It checks that wake is gated by each configuration field. It checks that a soft reset restores the registers but keeps data out and latches the new configuration value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned GB_DW      = 32;
    localparam int unsigned GB_AW      = 8;
    localparam int unsigned GB_CTRL_W  = 3;
    localparam int unsigned GB_DBT_W   = 8;
    localparam logic [GB_DW-1:0]     GB_CFG_MASK = 32'h0000_001D;
    localparam logic [GB_CTRL_W-1:0] GB_CTRL_RST = 3'd2;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_REV, SEL_SYSCFG, SEL_SYSSTAT,
        SEL_ST1, SEL_EN1, SEL_WKEN, SEL_ST2, SEL_EN2,
        SEL_CTRL, SEL_OE, SEL_DIN, SEL_DOUT,
        SEL_LVLLO, SEL_LVLHI, SEL_RISE, SEL_FALL,
        SEL_DBEN, SEL_DBTIME,
        SEL_EN1_CLR, SEL_EN1_SET, SEL_EN2_CLR, SEL_EN2_SET,
        SEL_WK_CLR, SEL_WK_SET, SEL_DO_CLR, SEL_DO_SET
    } reg_sel_e;

    // Word offset to register selector.
    function automatic reg_sel_e decode_sel(input logic [GB_AW-1:0] off);
        reg_sel_e s;
        case (off)
            8'h00: s = SEL_REV;
            8'h10: s = SEL_SYSCFG;
            8'h14: s = SEL_SYSSTAT;
            8'h18: s = SEL_ST1;
            8'h1C: s = SEL_EN1;
            8'h20: s = SEL_WKEN;
            8'h28: s = SEL_ST2;
            8'h2C: s = SEL_EN2;
            8'h30: s = SEL_CTRL;
            8'h34: s = SEL_OE;
            8'h38: s = SEL_DIN;
            8'h3C: s = SEL_DOUT;
            8'h40: s = SEL_LVLLO;
            8'h44: s = SEL_LVLHI;
            8'h48: s = SEL_RISE;
            8'h4C: s = SEL_FALL;
            8'h50: s = SEL_DBEN;
            8'h54: s = SEL_DBTIME;
            8'h60: s = SEL_EN1_CLR;
            8'h64: s = SEL_EN1_SET;
            8'h70: s = SEL_EN2_CLR;
            8'h74: s = SEL_EN2_SET;
            8'h80: s = SEL_WK_CLR;
            8'h84: s = SEL_WK_SET;
            8'h90: s = SEL_DO_CLR;
            8'h94: s = SEL_DO_SET;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Plain registers take a merged value on partial writes.
    function automatic logic is_plain(input reg_sel_e s);
        case (s)
            SEL_SYSCFG, SEL_EN1, SEL_WKEN, SEL_EN2, SEL_CTRL, SEL_OE,
            SEL_DOUT, SEL_LVLLO, SEL_LVLHI, SEL_RISE, SEL_FALL,
            SEL_DBEN, SEL_DBTIME: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= '0;
            prev <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
            prev <= stg[STAGES-1];
        end
    end

    assign cur = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] is_input,
    input  logic [W-1:0] sel_rise,
    input  logic [W-1:0] sel_fall,
    input  logic [W-1:0] sel_hi,
    input  logic [W-1:0] sel_lo,
    output logic [W-1:0] evt
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic rise_p, fall_p, lvl_p;
        assign rise_p = sel_rise[p] &  cur[p] & ~prev[p];
        assign fall_p = sel_fall[p] & ~cur[p] &  prev[p];
        assign lvl_p  = (sel_hi[p] & cur[p]) | (sel_lo[p] & ~cur[p]);
        assign evt[p] = is_input[p] & (rise_p | fall_p | lvl_p);
    end
endmodule

// File: rtl/gpio_bank_access.sv
module gpio_bank_access
    import gpio_bank_pkg::*;
(
    input  logic [GB_AW-1:0] addr,
    input  logic [1:0]       size,
    input  logic [GB_DW-1:0] wdata,
    input  logic [GB_DW-1:0] rd_word,
    output reg_sel_e         sel,
    output logic [GB_DW-1:0] wr_val,
    output logic [GB_DW-1:0] rdata
);
    logic [4:0]       sh;
    logic [GB_DW-1:0] smask, lmask, sval;

    assign sel = decode_sel({addr[GB_AW-1:2], 2'b00});
    assign sh  = {addr[1:0], 3'b000};

    always_comb begin
        unique case (size)
            2'd0:    smask = 32'h0000_00FF;
            2'd1:    smask = 32'h0000_FFFF;
            default: smask = '1;
        endcase
    end

    always_comb begin
        lmask  = smask << sh;
        sval   = (wdata & smask) << sh;
        wr_val = is_plain(sel) ? ((rd_word & ~lmask) | sval) : sval;
        rdata  = (rd_word >> sh) & smask;
    end
endmodule

// File: rtl/gpio_bank32.sv
module gpio_bank32
    import gpio_bank_pkg::*;
#(
    parameter logic [7:0]  REVISION    = 8'h25,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [GB_AW-1:0] bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [GB_DW-1:0] bus_wdata,
    output logic [GB_DW-1:0] bus_rdata,
    input  logic [GB_DW-1:0] pin_in,
    output logic [GB_DW-1:0] pin_out,
    output logic [GB_DW-1:0] pin_drive_en,
    output logic             irq1,
    output logic             irq2,
    output logic             wake
);
    localparam int unsigned DW = GB_DW;

    reg_sel_e        sel;
    logic [DW-1:0]   wr_val, rd_word, din, din_prev, evt;
    logic [DW-1:0]   r_cfg, r_oe, r_dout, r_lvllo, r_lvlhi, r_rise, r_fall;
    logic [DW-1:0]   r_en1, r_en2, r_wken, r_st1, r_st2, r_dben;
    logic [GB_CTRL_W-1:0] r_ctrl;
    logic [GB_DBT_W-1:0]  r_dbt;
    logic            r_wake, soft_rst, wake_hit;

    gpio_bank_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .cur(din), .prev(din_prev)
    );

    gpio_bank_detect #(.W(DW)) u_det (
        .cur(din), .prev(din_prev), .is_input(r_oe),
        .sel_rise(r_rise), .sel_fall(r_fall),
        .sel_hi(r_lvlhi), .sel_lo(r_lvllo), .evt(evt)
    );

    gpio_bank_access u_acc (
        .addr(bus_addr), .size(bus_size), .wdata(bus_wdata),
        .rd_word(rd_word), .sel(sel), .wr_val(wr_val), .rdata(bus_rdata)
    );

    always_comb begin
        unique case (sel)
            SEL_REV:     rd_word = {{(DW-8){1'b0}}, REVISION};
            SEL_SYSCFG:  rd_word = r_cfg;
            SEL_SYSSTAT: rd_word = 32'd1;
            SEL_ST1:     rd_word = r_st1;
            SEL_ST2:     rd_word = r_st2;
            SEL_EN1, SEL_EN1_CLR, SEL_EN1_SET: rd_word = r_en1;
            SEL_EN2, SEL_EN2_CLR, SEL_EN2_SET: rd_word = r_en2;
            SEL_WKEN, SEL_WK_CLR, SEL_WK_SET:  rd_word = r_wken;
            SEL_DOUT, SEL_DO_CLR, SEL_DO_SET:  rd_word = r_dout;
            SEL_CTRL:    rd_word = {{(DW-GB_CTRL_W){1'b0}}, r_ctrl};
            SEL_OE:      rd_word = r_oe;
            SEL_DIN:     rd_word = din;
            SEL_LVLLO:   rd_word = r_lvllo;
            SEL_LVLHI:   rd_word = r_lvlhi;
            SEL_RISE:    rd_word = r_rise;
            SEL_FALL:    rd_word = r_fall;
            SEL_DBEN:    rd_word = r_dben;
            SEL_DBTIME:  rd_word = {{(DW-GB_DBT_W){1'b0}}, r_dbt};
            default:     rd_word = '0;
        endcase
    end

    assign soft_rst = bus_we && (sel == SEL_SYSCFG) && wr_val[1];
    assign wake_hit = r_cfg[2] && (r_cfg[4:3] != 2'b00) && (|(evt & r_wken));

    always_ff @(posedge clk) begin
        if (rst) begin
            r_cfg  <= '0;  r_ctrl <= GB_CTRL_RST; r_oe  <= '1; r_dout <= '0;
            r_lvllo <= '0; r_lvlhi <= '0; r_rise <= '0; r_fall <= '0;
            r_en1  <= '0;  r_en2  <= '0;  r_wken <= '0;
            r_st1  <= '0;  r_st2  <= '0;  r_dben <= '0; r_dbt <= '0;
            r_wake <= 1'b0;
        end else if (soft_rst) begin
            r_cfg  <= wr_val & GB_CFG_MASK;
            r_ctrl <= GB_CTRL_RST; r_oe <= '1;
            r_lvllo <= '0; r_lvlhi <= '0; r_rise <= '0; r_fall <= '0;
            r_en1  <= '0;  r_en2  <= '0;  r_wken <= '0;
            r_st1  <= '0;  r_st2  <= '0;  r_dben <= '0; r_dbt <= '0;
            r_wake <= 1'b0;
        end else begin
            r_wake <= wake_hit;
            r_st1  <= r_st1 | evt;
            r_st2  <= r_st2 | evt;
            if (bus_we) begin
                unique case (sel)
                    SEL_SYSCFG:  r_cfg   <= wr_val & GB_CFG_MASK;
                    SEL_ST1:     r_st1   <= (r_st1 & ~wr_val) | evt;
                    SEL_ST2:     r_st2   <= (r_st2 & ~wr_val) | evt;
                    SEL_EN1:     r_en1   <= wr_val;
                    SEL_EN1_CLR: r_en1   <= r_en1 & ~wr_val;
                    SEL_EN1_SET: r_en1   <= r_en1 | wr_val;
                    SEL_EN2:     r_en2   <= wr_val;
                    SEL_EN2_CLR: r_en2   <= r_en2 & ~wr_val;
                    SEL_EN2_SET: r_en2   <= r_en2 | wr_val;
                    SEL_WKEN:    r_wken  <= wr_val;
                    SEL_WK_CLR:  r_wken  <= r_wken & ~wr_val;
                    SEL_WK_SET:  r_wken  <= r_wken | wr_val;
                    SEL_DOUT:    r_dout  <= wr_val;
                    SEL_DO_CLR:  r_dout  <= r_dout & ~wr_val;
                    SEL_DO_SET:  r_dout  <= r_dout | wr_val;
                    SEL_CTRL:    r_ctrl  <= wr_val[GB_CTRL_W-1:0];
                    SEL_OE:      r_oe    <= wr_val;
                    SEL_LVLLO:   r_lvllo <= wr_val;
                    SEL_LVLHI:   r_lvlhi <= wr_val;
                    SEL_RISE:    r_rise  <= wr_val;
                    SEL_FALL:    r_fall  <= wr_val;
                    SEL_DBEN:    r_dben  <= wr_val;
                    SEL_DBTIME:  r_dbt   <= wr_val[GB_DBT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign pin_out      = r_dout;
    assign pin_drive_en = ~r_oe;
    assign irq1         = |(r_st1 & r_en1);
    assign irq2         = |(r_st2 & r_en2);
    assign wake         = r_wake;
endmodule

// File: rtl/gpio_bank32_chk.sv
module gpio_bank32_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [7:0]  bus_addr,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq1,
    input logic        irq2,
    input logic        wake,
    input logic [31:0] st1,
    input logic [31:0] oe,
    input logic [31:0] en1,
    input logic [31:0] en2,
    input logic [31:0] cfg
);
    p_sysstatus_one_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 8'h14 && bus_size == 2'd2) |-> (bus_rdata == 32'd1));

    p_alias_set_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h64 && bus_size == 2'd2)
        |=> (en1 == ($past(en1) | $past(bus_wdata))));

    p_input_only_r6: assert property (@(posedge clk) disable iff (rst)
        ((st1 & ~$past(st1) & ~$past(oe)) == 32'd0));

    p_irq1_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        irq1 |-> (en1 != 32'd0));

    p_irq2_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        irq2 |-> (en2 != 32'd0));

    p_wake_gated_r9: assert property (@(posedge clk) disable iff (rst)
        wake |-> ($past(cfg[2]) && ($past(cfg[4:3]) != 2'b00)));

    p_soft_reset_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h10 && bus_size == 2'd2 && bus_wdata[1])
        |=> (oe == 32'hFFFF_FFFF && en1 == 32'd0 && en2 == 32'd0));
endmodule

bind gpio_bank32 gpio_bank32_chk u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq1(irq1), .irq2(irq2), .wake(wake),
    .st1(r_st1), .oe(r_oe), .en1(r_en1), .en2(r_en2), .cfg(r_cfg)
);

// File: tb/sim_gpio_bank32.sv
module sim_gpio_bank32;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_drive_en;
    logic        irq1, irq2, wake;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    gpio_bank32 u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_drive_en(pin_drive_en),
        .irq1(irq1), .irq2(irq2), .wake(wake)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd2, 8'h00, 32'h0000_0025, 4'd1},  // R1 revision
        '{1'b0, 2'd2, 8'h14, 32'h0000_0001, 4'd1},  // R1 status 0x14
        '{1'b0, 2'd2, 8'h30, 32'h0000_0002, 4'd1},  // R1 control
        '{1'b0, 2'd2, 8'h34, 32'hFFFF_FFFF, 4'd1},  // R1 direction
        '{1'b1, 2'd2, 8'h3C, 32'h0000_00F0, 4'd3},  // R3
        '{1'b1, 2'd2, 8'h94, 32'h0000_000F, 4'd3},
        '{1'b1, 2'd2, 8'h90, 32'h0000_0030, 4'd3},
        '{1'b0, 2'd2, 8'h90, 32'h0000_00CF, 4'd3},
        '{1'b0, 2'd2, 8'h3C, 32'h0000_00CF, 4'd3},
        '{1'b1, 2'd2, 8'h64, 32'h0000_0101, 4'd3},
        '{1'b1, 2'd2, 8'h60, 32'h0000_0001, 4'd3},
        '{1'b0, 2'd2, 8'h1C, 32'h0000_0100, 4'd3},
        '{1'b1, 2'd2, 8'h84, 32'h0000_00F0, 4'd3},
        '{1'b1, 2'd2, 8'h80, 32'h0000_0030, 4'd3},
        '{1'b0, 2'd2, 8'h84, 32'h0000_00C0, 4'd3},
        '{1'b1, 2'd2, 8'h10, 32'h0000_00FF, 4'd10}, // R10 soft reset
        '{1'b0, 2'd2, 8'h10, 32'h0000_001D, 4'd10},
        '{1'b0, 2'd2, 8'h20, 32'h0000_0000, 4'd10},
        '{1'b0, 2'd2, 8'h1C, 32'h0000_0000, 4'd10},
        '{1'b0, 2'd2, 8'h3C, 32'h0000_00CF, 4'd10},
        '{1'b1, 2'd2, 8'h10, 32'h0000_0000, 4'd10},
        '{1'b1, 2'd2, 8'h30, 32'h0000_00FF, 4'd10},
        '{1'b0, 2'd2, 8'h30, 32'h0000_0007, 4'd10},
        '{1'b1, 2'd0, 8'h3D, 32'h0000_00AB, 4'd11}, // R11 merge
        '{1'b0, 2'd2, 8'h3C, 32'h0000_ABCF, 4'd11},
        '{1'b1, 2'd1, 8'h3E, 32'h0000_1234, 4'd11},
        '{1'b0, 2'd2, 8'h3C, 32'h1234_ABCF, 4'd11},
        '{1'b0, 2'd0, 8'h3D, 32'h0000_00AB, 4'd12}, // R12 lanes
        '{1'b0, 2'd1, 8'h3E, 32'h0000_1234, 4'd12},
        '{1'b1, 2'd2, 8'h64, 32'h0000_0001, 4'd11}, // R11 alias no merge
        '{1'b1, 2'd0, 8'h65, 32'h0000_0002, 4'd11},
        '{1'b1, 2'd0, 8'h61, 32'h0000_0000, 4'd11},
        '{1'b0, 2'd2, 8'h1C, 32'h0000_0201, 4'd11},
        '{1'b1, 2'd2, 8'h50, 32'hDEAD_BEEF, 4'd13}, // R13
        '{1'b0, 2'd2, 8'h50, 32'hDEAD_BEEF, 4'd13},
        '{1'b1, 2'd2, 8'h54, 32'h0000_01FF, 4'd13},
        '{1'b0, 2'd2, 8'h54, 32'h0000_00FF, 4'd13},
        '{1'b1, 2'd2, 8'h38, 32'hFFFF_FFFF, 4'd12}, // R12 read-only
        '{1'b0, 2'd2, 8'h38, 32'h0000_0000, 4'd12},
        '{1'b1, 2'd2, 8'h00, 32'h0000_0000, 4'd12},
        '{1'b0, 2'd2, 8'h00, 32'h0000_0025, 4'd12},
        '{1'b0, 2'd2, 8'h58, 32'h0000_0000, 4'd12}  // R12 unmapped
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a,
                          input logic [1:0] sz, input logic [31:0] exp);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a; bus_size = sz;
        #2;
        chk(req, $sformatf("read %h", a), bus_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bus_we = 1'b0; bus_addr = 8'h00; bus_size = 2'd2; bus_wdata = '0;
        pin_in = '0;
        do_reset();

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) begin
                wr(TBL[i].addr, TBL[i].sz, TBL[i].data);
            end else begin
                rd_chk($sformatf("R%0d", TBL[i].req), TBL[i].addr, TBL[i].sz, TBL[i].data);
            end
        end
        chk("R2", "pin_out after table", pin_out, 32'h1234_ABCF);

        // R1: hard reset state at the pins
        do_reset();
        @(negedge clk);
        chk("R1", "pin_drive_en", pin_drive_en, 32'h0);
        chk("R1", "pin_out", pin_out, 32'h0);
        chk("R1", "irq/wake", {29'd0, irq1, irq2, wake}, 32'h0);

        // R2: direction and drive
        wr(8'h34, 2'd2, 32'hFFFF_0000);
        wr(8'h3C, 2'd2, 32'hA5A5_A5A5);
        chk("R2", "pin_drive_en", pin_drive_en, 32'h0000_FFFF);
        chk("R2", "pin_out", pin_out, 32'hA5A5_A5A5);
        wr(8'h34, 2'd2, 32'hFFFF_FFFF);

        // R4 rising edge sets both status, R8 irq follows enable
        wr(8'h48, 2'd2, 32'h1);
        wr(8'h1C, 2'd2, 32'h1);
        pin_in[0] = 1'b1;
        wait_cyc(4);
        rd_chk("R4", 8'h18, 2'd2, 32'h1);
        rd_chk("R4", 8'h28, 2'd2, 32'h1);
        chk("R8", "irq1", {31'd0, irq1}, 32'h1);
        chk("R8", "irq2 with no enable", {31'd0, irq2}, 32'h0);

        // R7 independent write-1-to-clear
        wr(8'h18, 2'd2, 32'h1);
        rd_chk("R7", 8'h18, 2'd2, 32'h0);
        rd_chk("R7", 8'h28, 2'd2, 32'h1);
        chk("R8", "irq1 after clear", {31'd0, irq1}, 32'h0);
        // R11 byte write to status must not clear other lanes
        wr(8'h29, 2'd0, 32'h0);
        rd_chk("R11", 8'h28, 2'd2, 32'h1);
        wr(8'h28, 2'd2, 32'h1);
        rd_chk("R7", 8'h28, 2'd2, 32'h0);

        // R4 falling only
        wr(8'h4C, 2'd2, 32'h2);
        pin_in[1] = 1'b1;
        wait_cyc(4);
        rd_chk("R4", 8'h18, 2'd2, 32'h0);
        pin_in[1] = 1'b0;
        wait_cyc(4);
        rd_chk("R4", 8'h18, 2'd2, 32'h2);
        wr(8'h18, 2'd2, 32'hFFFF_FFFF);
        wr(8'h28, 2'd2, 32'hFFFF_FFFF);

        // R5 level high re-asserts after clear
        pin_in[2] = 1'b1;
        wait_cyc(4);
        rd_chk("R5", 8'h18, 2'd2, 32'h0);
        wr(8'h44, 2'd2, 32'h4);
        wait_cyc(1);
        rd_chk("R5", 8'h18, 2'd2, 32'h4);
        wr(8'h18, 2'd2, 32'h4);
        rd_chk("R5", 8'h18, 2'd2, 32'h4);
        pin_in[2] = 1'b0;
        wait_cyc(4);
        wr(8'h18, 2'd2, 32'hFFFF_FFFF);
        wr(8'h28, 2'd2, 32'hFFFF_FFFF);
        rd_chk("R5", 8'h18, 2'd2, 32'h0);
        wr(8'h44, 2'd2, 32'h0);
        wr(8'h40, 2'd2, 32'h8);
        wait_cyc(1);
        rd_chk("R5", 8'h28, 2'd2, 32'h8);
        wr(8'h40, 2'd2, 32'h0);
        wr(8'h18, 2'd2, 32'hFFFF_FFFF);
        wr(8'h28, 2'd2, 32'hFFFF_FFFF);

        // R6 driven pin never sets status
        wr(8'h34, 2'd2, 32'hFFFF_FFEF);
        wr(8'h44, 2'd2, 32'h10);
        pin_in[4] = 1'b1;
        wait_cyc(4);
        rd_chk("R6", 8'h18, 2'd2, 32'h0);
        chk("R6", "pin_drive_en", pin_drive_en, 32'h10);
        wr(8'h44, 2'd2, 32'h0);
        wr(8'h34, 2'd2, 32'hFFFF_FFFF);
        pin_in[4] = 1'b0;

        // R9 wakeup gating
        wr(8'h84, 2'd2, 32'h20);
        wr(8'h44, 2'd2, 32'h20);
        pin_in[5] = 1'b1;
        wait_cyc(4);
        chk("R9", "wake with config 0", {31'd0, wake}, 32'h0);
        wr(8'h10, 2'd2, 32'h0C);
        wait_cyc(2);
        chk("R9", "wake enabled", {31'd0, wake}, 32'h1);
        wr(8'h74, 2'd2, 32'h20);
        chk("R8", "irq2", {31'd0, irq2}, 32'h1);
        chk("R8", "irq1 unaffected", {31'd0, irq1}, 32'h0);
        wr(8'h10, 2'd2, 32'h04);
        wait_cyc(2);
        chk("R9", "wake with idle field 0", {31'd0, wake}, 32'h0);

        // R10 soft reset
        wr(8'h10, 2'd2, 32'h02);
        rd_chk("R10", 8'h34, 2'd2, 32'hFFFF_FFFF);
        rd_chk("R10", 8'h2C, 2'd2, 32'h0);
        rd_chk("R10", 8'h44, 2'd2, 32'h0);
        rd_chk("R10", 8'h30, 2'd2, 32'h2);
        rd_chk("R10", 8'h10, 2'd2, 32'h0);
        chk("R10", "irq2 after soft reset", {31'd0, irq2}, 32'h0);
        pin_in = '0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule